// File: doc/BRIEF.md
# Internal clock source selector

This block chooses the system clock for a small controller from internal sources. A fast reference clock drives all of its logic and stands in for an 8 MHz internal oscillator. A single-cycle slow tick, synchronous to that reference, stands in for a separate 31 kHz low-power RC oscillator. A 3-bit frequency select picks either the undivided reference, a power-of-two postscaled version of it, or a low-frequency setting. The low-frequency setting is taken either from the slow tick or from the reference divided by a parameterised power of two. The result is a one-cycle clock enable. Each change of selection waits for the current divided period to end, so no enable period is ever cut short.

A 4-bit oscillator mode code decides which pins the two oscillator pads are handed to, and whether a divide-by-four clock-out appears on the second pad. Together with a software enable, it also decides whether the x4 frequency multiplier is reported active. The multiplier itself is not built; the block only reports its state. The block also reports whether the fast and slow oscillators must be running. This accounts for the active selection, the requested selection and four auxiliary features that keep the slow oscillator alive.

Top module: `intclk_select`

## Requirements
- R1: With frequency select 7 down to 1, once that setting is active, `sys_clk_en` is a single-cycle pulse every 2^(7 - freq_sel) reference cycles. A value of 7 gives every cycle and 1 gives every 64 cycles.
- R2: With frequency select 0, `lf_src_fast` = 1 gives a pulse every 2^LF_DIV_LOG2 cycles. With `lf_src_fast` = 0, `sys_clk_en` follows `slow_tick` in the same cycle.
- R3: The select inputs are sampled only in a cycle where `sys_clk_en` is high, and the sampled setting governs until the next pulse. A change made mid-period never shortens that period. The first period under a new fast setting counts in full from the boundary pulse.
- R4: `mult_active` is registered, one cycle after its inputs. It is high when the mode code is 0110, or when `mult_en_sw` is 1, the mode code is 1000 or 1001, and the frequency select is 110 or 111. Otherwise it is low.
- R5: `mult_en_rb` reads back the software enable one cycle later, only under the second condition of R4. It reads 0 in mode 0110 and in every other case.
- R6: `fast_osc_on` is high while the active setting counts the reference, and whenever the frequency select is non-zero or `lf_src_fast` is 1.
- R7: `slow_osc_on` is high while the active setting follows the slow tick, when frequency select 0 with `lf_src_fast` = 0 is requested, or when any of the power-up timer, fail-safe monitor, watchdog or two-speed start-up enables is 1.
- R8: Pin use by mode code works as follows. Codes 0011, 0100 and 1001 set `pin2_clkout`. Codes 0101, 0111 and 1000 set `pin2_gpio`. Codes 1000 and 1001 set `pin1_gpio`. All other codes set none of these flags.
- R9: An internal 2-bit count advances on every `sys_clk_en` pulse. `clkout_div4` equals its upper bit while `pin2_clkout` is 1, and is 0 otherwise.
- R10: `rst_n` low resets the block at once, and the internal reset is released on the second rising clock edge after `rst_n` rises. In reset, `mult_active`, `mult_en_rb` and `clkout_div4` are 0, and the postscaler runs at the undivided rate (`sys_clk_en` high) until its first boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle tick of the slow RC source |
| mode_code | input | 4 | Oscillator mode code |
| freq_sel | input | 3 | Frequency select |
| mult_en_sw | input | 1 | Software multiplier enable |
| lf_src_fast | input | 1 | Low setting source: 1 = divided reference, 0 = slow tick |
| pwrup_tmr_en | input | 1 | Power-up timer enable |
| fail_safe_en | input | 1 | Fail-safe clock monitor enable |
| wdog_en | input | 1 | Watchdog enable |
| two_speed_en | input | 1 | Two-speed start-up enable |
| sys_clk_en | output | 1 | Selected system clock enable |
| mult_active | output | 1 | x4 multiplier active |
| mult_en_rb | output | 1 | Effective software multiplier enable |
| clkout_div4 | output | 1 | System clock divided by four on the second pad |
| pin1_gpio | output | 1 | First pad is general-purpose I/O |
| pin2_gpio | output | 1 | Second pad is general-purpose I/O |
| pin2_clkout | output | 1 | Second pad drives the clock-out |
| fast_osc_on | output | 1 | Fast reference must run |
| slow_osc_on | output | 1 | Slow RC source must run |

## Verification
The bench builds the block with LF_DIV_LOG2 = 4, so the reference-derived low setting repeats every 16 cycles instead of 256. At that value every frequency setting, including the slowest 64-cycle postscale, completes many periods within a short run. Selection changes can then be placed at many offsets inside a period, which exercises the boundary rule. The slow tick comes every 23 cycles, so switches between a counted source and a tick-driven source fall at varied phases.

// File: rtl/intclk_pkg.sv
package intclk_pkg;

  localparam logic [3:0] MODE_RC_CKO  = 4'b0011;
  localparam logic [3:0] MODE_EXT_CKO = 4'b0100;
  localparam logic [3:0] MODE_EXT_IO  = 4'b0101;
  localparam logic [3:0] MODE_HS_X4   = 4'b0110;
  localparam logic [3:0] MODE_RC_IO   = 4'b0111;
  localparam logic [3:0] MODE_INT_IO  = 4'b1000;
  localparam logic [3:0] MODE_INT_CKO = 4'b1001;

  localparam logic [2:0] FSEL_LOW = 3'b000;
  localparam logic [2:0] FSEL_TOP = 3'b111;

  typedef struct packed {
    logic pin1_gpio;
    logic pin2_gpio;
    logic pin2_clkout;
  } pin_map_t;

endpackage

// File: rtl/intclk_rst_sync.sv
module intclk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/intclk_mode_decode.sv
module intclk_mode_decode
  import intclk_pkg::*;
(
  input  logic [3:0] mode_code,
  input  logic [2:0] freq_sel,
  input  logic       mult_sw,
  output pin_map_t   pins,
  output logic       mult_req,
  output logic       rb_req
);
  logic int_mode;
  logic top_rates;

  always_comb begin
    int_mode  = (mode_code == MODE_INT_IO) || (mode_code == MODE_INT_CKO);
    top_rates = freq_sel[2] & freq_sel[1];
    rb_req    = mult_sw & int_mode & top_rates;
    mult_req  = (mode_code == MODE_HS_X4) | rb_req;
    pins      = '0;
    case (mode_code)
      MODE_RC_CKO, MODE_EXT_CKO: pins.pin2_clkout = 1'b1;
      MODE_EXT_IO, MODE_RC_IO:   pins.pin2_gpio   = 1'b1;
      MODE_INT_CKO: begin
        pins.pin1_gpio   = 1'b1;
        pins.pin2_clkout = 1'b1;
      end
      MODE_INT_IO: begin
        pins.pin1_gpio = 1'b1;
        pins.pin2_gpio = 1'b1;
      end
      default: pins = '0;
    endcase
  end
endmodule

// File: rtl/intclk_mult_flag.sv
module intclk_mult_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic mult_req,
  input  logic rb_req,
  output logic mult_q,
  output logic rb_q
);
  logic mult_d;
  logic rb_d;

  always_comb begin
    mult_d = mult_req;
    rb_d   = rb_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_q <= 1'b0;
      rb_q   <= 1'b0;
    end else begin
      mult_q <= mult_d;
      rb_q   <= rb_d;
    end
  end
endmodule

// File: rtl/intclk_postscaler.sv
module intclk_postscaler
  import intclk_pkg::*;
#(
  parameter int LF_DIV_LOG2 = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] freq_sel,
  input  logic       lf_src_fast,
  input  logic       slow_tick,
  output logic       clk_en,
  output logic       cur_slow
);
  localparam int CW = (LF_DIV_LOG2 > 6) ? LF_DIV_LOG2 : 6;
  localparam int LW = $clog2(CW + 1);

  logic          slow_q, slow_d;
  logic [LW-1:0] log2_q, log2_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] term_mask;
  logic          req_slow;
  logic [LW-1:0] req_log2;

  for (genvar i = 0; i < CW; i++) begin : g_mask
    assign term_mask[i] = (LW'(i) < log2_q);
  end

  always_comb begin
    req_slow = (freq_sel == FSEL_LOW) && !lf_src_fast;
    if (freq_sel == FSEL_LOW) req_log2 = LW'(LF_DIV_LOG2);
    else                      req_log2 = LW'(FSEL_TOP - freq_sel);
    clk_en = slow_q ? slow_tick : (cnt_q == term_mask);
    slow_d = slow_q;
    log2_d = log2_q;
    cnt_d  = cnt_q;
    if (clk_en) begin
      slow_d = req_slow;
      log2_d = req_log2;
      cnt_d  = '0;
    end else if (!slow_q) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q <= 1'b0;
      log2_q <= '0;
      cnt_q  <= '0;
    end else begin
      slow_q <= slow_d;
      log2_q <= log2_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cur_slow = slow_q;
endmodule

// File: rtl/intclk_div4.sv
module intclk_div4 (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic phase_hi
);
  logic [1:0] cnt_q, cnt_d;

  always_comb cnt_d = tick ? cnt_q + 2'd1 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= 2'd0;
    else        cnt_q <= cnt_d;
  end

  assign phase_hi = cnt_q[1];
endmodule

// File: rtl/intclk_select.sv
module intclk_select
  import intclk_pkg::*;
#(
  parameter int LF_DIV_LOG2 = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_tick,
  input  logic [3:0] mode_code,
  input  logic [2:0] freq_sel,
  input  logic       mult_en_sw,
  input  logic       lf_src_fast,
  input  logic       pwrup_tmr_en,
  input  logic       fail_safe_en,
  input  logic       wdog_en,
  input  logic       two_speed_en,
  output logic       sys_clk_en,
  output logic       mult_active,
  output logic       mult_en_rb,
  output logic       clkout_div4,
  output logic       pin1_gpio,
  output logic       pin2_gpio,
  output logic       pin2_clkout,
  output logic       fast_osc_on,
  output logic       slow_osc_on
);
  logic     rst_sync_n;
  pin_map_t pins;
  logic     mult_req, rb_req;
  logic     cur_slow;
  logic     div4_hi;
  logic     req_low_slow;
  logic     aux_any;

  intclk_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  intclk_mode_decode u_dec (
    .mode_code(mode_code), .freq_sel(freq_sel), .mult_sw(mult_en_sw),
    .pins(pins), .mult_req(mult_req), .rb_req(rb_req)
  );

  intclk_mult_flag u_mult (
    .clk(clk), .rst_n(rst_sync_n), .mult_req(mult_req), .rb_req(rb_req),
    .mult_q(mult_active), .rb_q(mult_en_rb)
  );

  intclk_postscaler #(.LF_DIV_LOG2(LF_DIV_LOG2)) u_ps (
    .clk(clk), .rst_n(rst_sync_n), .freq_sel(freq_sel),
    .lf_src_fast(lf_src_fast), .slow_tick(slow_tick),
    .clk_en(sys_clk_en), .cur_slow(cur_slow)
  );

  intclk_div4 u_div4 (
    .clk(clk), .rst_n(rst_sync_n), .tick(sys_clk_en), .phase_hi(div4_hi)
  );

  always_comb begin
    req_low_slow = (freq_sel == FSEL_LOW) && !lf_src_fast;
    aux_any      = pwrup_tmr_en | fail_safe_en | wdog_en | two_speed_en;
    fast_osc_on  = !cur_slow || (freq_sel != FSEL_LOW) || lf_src_fast;
    slow_osc_on  = cur_slow || req_low_slow || aux_any;
    pin1_gpio    = pins.pin1_gpio;
    pin2_gpio    = pins.pin2_gpio;
    pin2_clkout  = pins.pin2_clkout;
    clkout_div4  = pins.pin2_clkout & div4_hi;
  end
endmodule

// File: rtl/intclk_select_chk.sv
module intclk_select_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] mode_code,
  input logic [2:0] freq_sel,
  input logic       mult_en_sw,
  input logic       aux_any,
  input logic       sys_clk_en,
  input logic       mult_active,
  input logic       mult_en_rb,
  input logic       clkout_div4,
  input logic       pin2_gpio,
  input logic       pin2_clkout,
  input logic       fast_osc_on,
  input logic       slow_osc_on
);
  AST_MULT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    mult_active |-> $past(mode_code == 4'b0110 || (mult_en_sw && mode_code[3:1] == 3'b100 && freq_sel[2:1] == 2'b11))); // R4
  AST_RB_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mult_en_rb |-> $past(mult_en_sw && mode_code[3:1] == 3'b100 && freq_sel[2:1] == 2'b11)); // R5
  AST_RB_WITH_MULT: assert property (@(posedge clk) disable iff (!rst_n)
    mult_en_rb |-> mult_active); // R5
  AST_FAST_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_sel != 3'b000) |-> fast_osc_on); // R6
  AST_SLOW_FOR_AUX: assert property (@(posedge clk) disable iff (!rst_n)
    aux_any |-> slow_osc_on); // R7
  AST_PIN2_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pin2_gpio && pin2_clkout)); // R8
  AST_CLKOUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    clkout_div4 |-> pin2_clkout); // R9
  AST_CLKOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pin2_clkout && $past(pin2_clkout) && !$past(sys_clk_en)) |-> $stable(clkout_div4)); // R9
endmodule

bind intclk_select intclk_select_chk i_chk (
  .clk(clk), .rst_n(rst_sync_n), .mode_code(mode_code), .freq_sel(freq_sel),
  .mult_en_sw(mult_en_sw), .aux_any(aux_any), .sys_clk_en(sys_clk_en),
  .mult_active(mult_active), .mult_en_rb(mult_en_rb), .clkout_div4(clkout_div4),
  .pin2_gpio(pin2_gpio), .pin2_clkout(pin2_clkout),
  .fast_osc_on(fast_osc_on), .slow_osc_on(slow_osc_on)
);

// File: tb/test_intclk_select.sv
`timescale 1ns/1ps
module test_intclk_select;
  localparam int LF = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic slow_tick;
  logic [3:0] mode_code;
  logic [2:0] freq_sel;
  logic mult_en_sw, lf_src_fast;
  logic [3:0] aux;
  logic sys_clk_en, mult_active, mult_en_rb, clkout_div4;
  logic pin1_gpio, pin2_gpio, pin2_clkout, fast_osc_on, slow_osc_on;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  intclk_select #(.LF_DIV_LOG2(LF)) i_intclk_select (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .mode_code(mode_code),
    .freq_sel(freq_sel), .mult_en_sw(mult_en_sw), .lf_src_fast(lf_src_fast),
    .pwrup_tmr_en(aux[0]), .fail_safe_en(aux[1]), .wdog_en(aux[2]), .two_speed_en(aux[3]),
    .sys_clk_en(sys_clk_en), .mult_active(mult_active), .mult_en_rb(mult_en_rb),
    .clkout_div4(clkout_div4), .pin1_gpio(pin1_gpio), .pin2_gpio(pin2_gpio),
    .pin2_clkout(pin2_clkout), .fast_osc_on(fast_osc_on), .slow_osc_on(slow_osc_on)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // slow RC stand-in: one tick every 23 cycles, driven after the edge
  int stc = 0;
  always begin
    @(posedge clk); #1;
    stc = (stc + 1) % 23;
    slow_tick = (stc == 0);
  end

  // behavioural reference model
  logic [1:0] m_rs;
  bit m_slow, m_fromlf, m_mult, m_rb;
  int m_per, m_cnt, m_k4;

  function automatic bit int_mode(input logic [3:0] m);
    return (m == 4'd8) || (m == 4'd9);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_rs <= 2'b00;
    else        m_rs <= {m_rs[0], 1'b1};
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !m_rs[1]) begin
      m_slow = 0; m_fromlf = 0; m_per = 1; m_cnt = 0; m_k4 = 0; m_mult = 0; m_rb = 0;
    end else begin
      bit pulse;
      pulse = m_slow ? bit'(slow_tick) : (m_cnt == m_per - 1);
      if (pulse) begin
        m_slow   = (freq_sel == 0) && !lf_src_fast;
        m_fromlf = (freq_sel == 0);
        m_per    = (freq_sel == 0) ? (1 << LF) : (1 << (7 - int'(freq_sel)));
        m_cnt    = 0;
        m_k4     = (m_k4 + 1) % 4;
      end else if (!m_slow) begin
        m_cnt = m_cnt + 1;
      end
      m_rb   = mult_en_sw && int_mode(mode_code) && (freq_sel >= 3'd6);
      m_mult = (mode_code == 4'b0110) || m_rb;
    end
  end

  always @(negedge clk) begin
    bit e_en, e_p1, e_p2g, e_p2c;
    e_en = m_slow ? bit'(slow_tick) : (m_cnt == m_per - 1);
    chk((m_slow || m_fromlf) ? "R2 sys_clk_en" : "R1 sys_clk_en", sys_clk_en, e_en);
    chk("R4 mult_active", mult_active, m_mult);
    chk("R5 mult_en_rb", mult_en_rb, m_rb);
    chk("R6 fast_osc_on", fast_osc_on, !m_slow || freq_sel != 0 || lf_src_fast);
    chk("R7 slow_osc_on", slow_osc_on, m_slow || (freq_sel == 0 && !lf_src_fast) || (aux != 0));
    e_p1 = int_mode(mode_code);
    e_p2g = (mode_code == 4'd5) || (mode_code == 4'd7) || (mode_code == 4'd8);
    e_p2c = (mode_code == 4'd3) || (mode_code == 4'd4) || (mode_code == 4'd9);
    chk("R8 pin1_gpio", pin1_gpio, e_p1);
    chk("R8 pin2_gpio", pin2_gpio, e_p2g);
    chk("R8 pin2_clkout", pin2_clkout, e_p2c);
    chk("R9 clkout_div4", clkout_div4, e_p2c && (m_k4 >= 2));
  end

  task automatic step_in(input logic [2:0] fs, input logic lf);
    @(posedge clk); #1;
    freq_sel = fs; lf_src_fast = lf;
  endtask

  initial begin
    #800000;
    n_cmp++; n_bad++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; slow_tick = 0; mode_code = 4'd9; freq_sel = 3'd7;
    mult_en_sw = 0; lf_src_fast = 1; aux = 4'd0;
    repeat (3) begin
      @(negedge clk);
      chk("R10 reset mult_active", mult_active, 1'b0);
      chk("R10 reset clkout_div4", clkout_div4, 1'b0);
      chk("R10 reset mult_en_rb", mult_en_rb, 1'b0);
    end
    @(posedge clk); #1 rst_n = 1;

    // R1: every postscaled setting
    for (int f = 7; f >= 1; f--) begin
      step_in(f[2:0], 1'b1);
      repeat (150) @(posedge clk);
    end
    // R2: low setting from each source
    step_in(3'd0, 1'b1); repeat (100) @(posedge clk);
    step_in(3'd0, 1'b0); repeat (120) @(posedge clk);

    // R3: changes at scattered offsets
    for (int i = 0; i < 60; i++) begin
      step_in(3'((i * 5 + 3) % 8), 1'(i % 2));
      repeat ((i * 7) % 29 + 3) @(posedge clk);
    end

    // R4 R5 R8: mode sweep
    for (int m = 0; m < 16; m++)
      for (int s = 0; s < 2; s++)
        for (int f = 5; f < 8; f++) begin
          @(posedge clk); #1;
          mode_code = 4'(m); mult_en_sw = 1'(s); freq_sel = 3'(f);
          repeat (3) @(posedge clk);
        end

    // R7: auxiliary enables one at a time
    mode_code = 4'd9; mult_en_sw = 0;
    step_in(3'd7, 1'b1); repeat (4) @(posedge clk);
    for (int a = 0; a < 4; a++) begin
      @(posedge clk); #1 aux = 4'(1 << a);
      repeat (5) @(posedge clk);
    end
    @(posedge clk); #1 aux = 4'd0;
    repeat (5) @(posedge clk);

    // R3 directed: mid-period change keeps the full old period
    step_in(3'd1, 1'b1);
    do @(negedge clk); while (!sys_clk_en);
    do @(negedge clk); while (!sys_clk_en);
    begin
      int gap;
      repeat (10) @(posedge clk);
      #1 freq_sel = 3'd7;
      gap = 10;
      forever begin
        @(negedge clk);
        if (sys_clk_en) break;
        gap++;
      end
      chk("R3 full old period kept", gap == 64, 1'b1);
      if (gap != 64) $display("FAIL R3 gap: actual %0d expected 64", gap);
      @(negedge clk);
      chk("R3 new setting after boundary", sys_clk_en, 1'b1);
    end

    // R10: reset mid-run
    mode_code = 4'd6; step_in(3'd5, 1'b1);
    repeat (20) @(posedge clk);
    #1 rst_n = 0;
    repeat (3) begin
      @(negedge clk);
      chk("R10 mid-run reset mult_active", mult_active, 1'b0);
      chk("R10 mid-run reset clkout_div4", clkout_div4, 1'b0);
    end
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk); chk("R10 held after release", mult_active, 1'b0);
    repeat (40) @(posedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule